// File: doc/BRIEF.md
# Segmented First-Bit Mask Generator

This block takes a source mask and builds a derived mask from the lowest set source bit. It has three shapes. The first sets every bit below that source bit. The second also sets the source bit itself. The third sets only the source bit. A second mask of restart markers, enabled by a flag, makes the scan segmented. After the scan has stopped at a set source bit, a marker at a later position restarts the setting run from that position.

The scan is a carry chain: a "setting" state passes from the LSB towards the MSB. A parameter selects how this chain is built, either as a ripple chain or as a logarithmic parallel prefix. The block samples its operands when a start strobe is high. The result and a one-cycle done pulse appear on the next clock edge.

Top module: `seg_first_mask`

## Requirements
- R1: In mode 00 with restart disabled, every result bit below the lowest set source bit is 1, and that bit and all bits above it are 0. Source 0x94 gives 0x03.
- R2: In mode 01 with restart disabled, the result is the mode 00 result plus the lowest set source bit. Source 0x94 gives 0x07.
- R3: In mode 10 with restart disabled, only the lowest set source bit is 1 in the result. Source 0x94 gives 0x04.
- R4: Mode code 11 is reserved and always gives an all-zero result.
- R5: An all-zero source gives all ones in modes 00 and 01 and all zeros in mode 10.
- R6: The scan starts in setting state when restart is disabled or when restart-mask bit 0 is 1. Otherwise it starts in searching state, and no bit is set until a marker appears. With restart mask 0x08 and a zero source, mode 00 gives every bit from 3 upward.
- R7: In searching state with restart enabled, a marker at a position whose source bit is 0 re-enters setting state, and that position is set in modes 00 and 01. Source 0x94 with markers 0xC3 in mode 00 gives 0x43.
- R8: A set source bit always ends setting state at its position, even when a marker stands at that same position. That position then counts as a stop: it is 0 in mode 00 and 1 in modes 01 and 10, and setting does not continue past it. Source 0x94 with markers 0x11 gives 0x03, 0x17 and 0x14 in modes 00, 01 and 10.
- R9: With restart enabled, modes 01 and 10 set the stopping source bit of every segment. Source 0x94 with markers 0xC3 gives 0xC7 in mode 01 and 0x84 in mode 10.
- R10: When restart is disabled, the restart mask has no effect on the result.
- R11: done_o is 1 exactly in the cycle after a cycle with start_i high. The result changes only on a start and holds its value otherwise.
- R12: A synchronous reset clears result_o and done_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Sample the operands and produce a result on the next edge |
| src_i | input | W | Source mask |
| marks_i | input | W | Restart marker mask |
| marks_en_i | input | 1 | Enables the restart markers |
| mode_i | input | 2 | 00 before-first, 01 including-first, 10 only-first, 11 reserved |
| result_o | output | W | Derived mask |
| done_o | output | 1 | One-cycle pulse when result_o is updated |

## Verification
The bench drives sparse source and marker masks, so that segments and marker positions often fall on the same bit. A design that lets the marker win such a collision would keep setting past a stop and fill the upper bits. A design that starts in setting state regardless of marker bit 0 would set the low bits when a search should produce zeros there. The all-zero source and the reserved code show an off-by-one seed or a missing default as a wrong all-ones or all-zero word. A bit-serial model checks random masks, which would expose a prefix stage with a wrong distance as stray bits at high positions.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
   typedef enum logic [1:0] {
      SHAPE_BEFORE  = 2'b00,
      SHAPE_INCL    = 2'b01,
      SHAPE_ONLY    = 2'b10,
      SHAPE_RSVD    = 2'b11
   } shape_e;

   typedef enum logic {
      CHAIN_RIPPLE = 1'b0,
      CHAIN_PREFIX = 1'b1
   } chain_e;
endpackage

// File: rtl/sfm_scan.sv
// Produces, for each bit, whether the setting state enters that bit from below.
// Per bit: kill = source bit set, gen = restart marker; state_out = (state_in | gen) & ~kill.
module sfm_scan #(
   parameter int unsigned     W     = 64,
   parameter sfm_pkg::chain_e CHAIN = sfm_pkg::CHAIN_PREFIX
) (
   input  logic         seed_i,
   input  logic [W-1:0] gen_i,
   input  logic [W-1:0] kill_i,
   output logic [W-1:0] cin_o
);
   localparam int unsigned LVL = (W > 1) ? $clog2(W) : 1;

   if (W < 2) begin : g_bad_width
      $error("sfm_scan: W must be at least 2");
   end

   if (CHAIN == sfm_pkg::CHAIN_RIPPLE) begin : g_ripple
      always_comb begin
         logic run;
         run = seed_i;
         for (int i = 0; i < W; i++) begin
            cin_o[i] = run;
            run      = (run | gen_i[i]) & ~kill_i[i];
         end
      end
   end else begin : g_prefix
      // carry-out of bit i as a (G,P) prefix; the seed is folded into bit 0
      logic [W-1:0] gg [0:LVL];
      logic [W-1:0] pp [0:LVL];

      always_comb begin
         pp[0]    = ~kill_i;
         gg[0]    = gen_i & ~kill_i;
         gg[0][0] = (seed_i | gen_i[0]) & ~kill_i[0];
         pp[0][0] = 1'b0;
      end

      for (genvar k = 0; k < LVL; k++) begin : g_lvl
         localparam int unsigned D = 1 << k;
         for (genvar i = 0; i < W; i++) begin : g_bit
            if (i >= D) begin : g_comb
               assign gg[k+1][i] = gg[k][i] | (pp[k][i] & gg[k][i-D]);
               assign pp[k+1][i] = pp[k][i] & pp[k][i-D];
            end else begin : g_pass
               assign gg[k+1][i] = gg[k][i];
               assign pp[k+1][i] = pp[k][i];
            end
         end
      end

      assign cin_o = {gg[LVL][W-2:0], seed_i};
   end
endmodule

// File: rtl/sfm_shape.sv
// Turns the per-bit setting state into the selected output shape.
module sfm_shape #(
   parameter int unsigned W = 64
) (
   input  logic [W-1:0]    cin_i,
   input  logic [W-1:0]    gen_i,
   input  logic [W-1:0]    src_i,
   input  sfm_pkg::shape_e shape_i,
   output logic [W-1:0]    mask_o
);
   logic [W-1:0] active;

   assign active = cin_i | gen_i;

   always_comb begin
      unique case (shape_i)
         sfm_pkg::SHAPE_BEFORE: mask_o = active & ~src_i;
         sfm_pkg::SHAPE_INCL:   mask_o = active;
         sfm_pkg::SHAPE_ONLY:   mask_o = active & src_i;
         default:               mask_o = '0;
      endcase
   end
endmodule

// File: rtl/seg_first_mask.sv
module seg_first_mask #(
   parameter int unsigned     W     = 64,
   parameter sfm_pkg::chain_e CHAIN = sfm_pkg::CHAIN_PREFIX
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         start_i,
   input  logic [W-1:0] src_i,
   input  logic [W-1:0] marks_i,
   input  logic         marks_en_i,
   input  logic [1:0]   mode_i,
   output logic [W-1:0] result_o,
   output logic         done_o
);
   import sfm_pkg::*;

   if (W < 2) begin : g_bad_width
      $error("seg_first_mask: W must be at least 2");
   end

   logic [W-1:0] gen;
   logic [W-1:0] cin;
   logic [W-1:0] mask_n;
   logic         seed;

   assign gen  = marks_en_i ? marks_i : '0;
   assign seed = ~marks_en_i;

   sfm_scan #(.W(W), .CHAIN(CHAIN)) i_scan (
      .seed_i (seed),
      .gen_i  (gen),
      .kill_i (src_i),
      .cin_o  (cin)
   );

   sfm_shape #(.W(W)) i_shape (
      .cin_i   (cin),
      .gen_i   (gen),
      .src_i   (src_i),
      .shape_i (shape_e'(mode_i)),
      .mask_o  (mask_n)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         result_o <= '0;
         done_o   <= 1'b0;
      end else begin
         done_o <= start_i;
         if (start_i) result_o <= mask_n;
      end
   end

   // R11: done follows a start by exactly one cycle
   assert_done_after_start_R11: assert property (@(posedge clk) disable iff (rst)
      start_i |=> done_o);
   assert_done_needs_start_R11: assert property (@(posedge clk) disable iff (rst)
      !start_i |=> !done_o);
   assert_hold_without_start_R11: assert property (@(posedge clk) disable iff (rst)
      !start_i |=> $stable(result_o));
   // R4: reserved code clears the result
   assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (rst)
      (start_i && mode_i == 2'b11) |=> (result_o == '0));
   // R1: before-first never overlaps the source
   assert_before_disjoint_R1: assert property (@(posedge clk) disable iff (rst)
      (start_i && mode_i == 2'b00) |=> ((result_o & $past(src_i)) == '0));
   // R3: without restart, only-first has at most one bit
   assert_only_single_R3: assert property (@(posedge clk) disable iff (rst)
      (start_i && mode_i == 2'b10 && !marks_en_i) |=> $onehot0(result_o));
   // R2: without restart, including-first touches at most one source bit
   assert_incl_one_src_R2: assert property (@(posedge clk) disable iff (rst)
      (start_i && mode_i == 2'b01 && !marks_en_i) |=> $onehot0(result_o & $past(src_i)));
endmodule

// File: tb/test_seg_first_mask.sv
`timescale 1ns/1ps
module test_seg_first_mask;
   localparam int unsigned W = 64;

   logic         clk = 1'b0;
   logic         rst;
   logic         start_i;
   logic [W-1:0] src_i;
   logic [W-1:0] marks_i;
   logic         marks_en_i;
   logic [1:0]   mode_i;
   logic [W-1:0] result_o;
   logic         done_o;

   int checks = 0;
   int errors = 0;
   logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

   always #4 clk = ~clk;

   seg_first_mask #(.W(W)) i_seg_first_mask (
      .clk(clk), .rst(rst), .start_i(start_i), .src_i(src_i),
      .marks_i(marks_i), .marks_en_i(marks_en_i), .mode_i(mode_i),
      .result_o(result_o), .done_o(done_o)
   );

   // bit-serial model written from the requirements
   function automatic logic [W-1:0] model(input logic [W-1:0] s, input logic [W-1:0] m,
                                          input logic en, input logic [1:0] md);
      logic [W-1:0] r;
      logic setting;
      r = '0;
      if (md == 2'b11) return r;
      setting = !en || m[0];
      for (int i = 0; i < W; i++) begin
         if (!setting && en && m[i]) setting = 1'b1;
         if (setting) begin
            if (s[i]) begin
               r[i] = (md != 2'b00);
               setting = 1'b0;
            end else begin
               r[i] = (md != 2'b10);
            end
         end
      end
      return r;
   endfunction

   function automatic logic [63:0] next_rand(input logic [63:0] x);
      logic [63:0] y;
      y = x ^ (x << 13);
      y = y ^ (y >> 7);
      y = y ^ (y << 17);
      return y;
   endfunction

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one operation: drive at negedge, sample at the negedge after the capturing edge
   task automatic run_op(input string req, input logic [W-1:0] s, input logic [W-1:0] m,
                         input logic en, input logic [1:0] md, input logic [W-1:0] exp);
      @(negedge clk);
      src_i = s; marks_i = m; marks_en_i = en; mode_i = md; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check(req, result_o, exp);
      check({req, " R11 done"}, W'(done_o), W'(1));
   endtask

   task automatic t_reset;
      @(negedge clk);
      check("R12 reset result", result_o, '0);
      check("R12 reset done", W'(done_o), '0);
   endtask

   task automatic t_plain_shapes;
      run_op("R1 before 0x94", 64'h94, '0, 1'b0, 2'b00, 64'h03);
      run_op("R2 incl 0x94",   64'h94, '0, 1'b0, 2'b01, 64'h07);
      run_op("R3 only 0x94",   64'h94, '0, 1'b0, 2'b10, 64'h04);
      run_op("R1 before msb",  64'h8000_0000_0000_0000, '0, 1'b0, 2'b00, 64'h7FFF_FFFF_FFFF_FFFF);
      run_op("R3 only bit0",   64'h8000_0000_0000_0001, '0, 1'b0, 2'b10, 64'h1);
   endtask

   task automatic t_zero_src;
      run_op("R5 zero before", '0, '0, 1'b0, 2'b00, '1);
      run_op("R5 zero incl",   '0, '0, 1'b0, 2'b01, '1);
      run_op("R5 zero only",   '0, '0, 1'b0, 2'b10, '0);
   endtask

   task automatic t_reserved;
      run_op("R4 reserved plain",   64'h94, '0, 1'b0, 2'b11, '0);
      run_op("R4 reserved restart", '0, 64'hC3, 1'b1, 2'b11, '0);
   endtask

   task automatic t_start_state;
      run_op("R6 search start", '0, 64'h08, 1'b1, 2'b00, ~64'h7);
      run_op("R6 set start",    64'h94, 64'h01, 1'b1, 2'b00, 64'h03);
      run_op("R6 search none",  64'h94, '0, 1'b1, 2'b01, '0);
   endtask

   task automatic t_segments;
      run_op("R7 restart before", 64'h94, 64'hC3, 1'b1, 2'b00, 64'h43);
      run_op("R9 restart incl",   64'h94, 64'hC3, 1'b1, 2'b01, 64'hC7);
      run_op("R9 restart only",   64'h94, 64'hC3, 1'b1, 2'b10, 64'h84);
   endtask

   task automatic t_collision;
      run_op("R8 clash before", 64'h94, 64'h11, 1'b1, 2'b00, 64'h03);
      run_op("R8 clash incl",   64'h94, 64'h11, 1'b1, 2'b01, 64'h17);
      run_op("R8 clash only",   64'h94, 64'h11, 1'b1, 2'b10, 64'h14);
   endtask

   task automatic t_marks_ignored;
      run_op("R10 ignored before", 64'h94, 64'hFFFF_0000_00C3_0AF0, 1'b0, 2'b00, 64'h03);
      run_op("R10 ignored only",   64'h94, 64'h0000_0000_0000_00FE, 1'b0, 2'b10, 64'h04);
   endtask

   task automatic t_hold;
      logic [W-1:0] kept;
      run_op("R11 hold setup", 64'h10, '0, 1'b0, 2'b00, 64'h0F);
      kept = result_o;
      @(negedge clk);
      src_i = '0; marks_i = '1; marks_en_i = 1'b1; mode_i = 2'b01;
      @(negedge clk);
      check("R11 done low", W'(done_o), '0);
      @(negedge clk);
      check("R11 result held", result_o, kept);
   endtask

   task automatic t_random;
      for (int n = 0; n < 60; n++) begin
         logic [W-1:0] s, m;
         rng = next_rand(rng); s = rng;
         rng = next_rand(rng); s = s & rng;
         rng = next_rand(rng); s = s & rng;
         rng = next_rand(rng); m = rng;
         rng = next_rand(rng); m = m & rng;
         for (int md = 0; md < 4; md++) begin
            for (int en = 0; en < 2; en++) begin
               run_op("R1 R2 R3 R7 R8 R9 random", s, m, en[0], md[1:0],
                      model(s, m, en[0], md[1:0]));
            end
         end
      end
   endtask

   task automatic t_reset_mid;
      run_op("R12 pre-reset", 64'h80, '0, 1'b0, 2'b01, 64'hFF);
      @(negedge clk);
      rst = 1'b1; start_i = 1'b1;
      @(negedge clk);
      rst = 1'b0; start_i = 1'b0;
      check("R12 result cleared", result_o, '0);
      check("R12 done cleared", W'(done_o), '0);
   endtask

   task automatic summary;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
   end

   initial begin
      rst = 1'b1; start_i = 1'b0; src_i = '0; marks_i = '0; marks_en_i = 1'b0; mode_i = 2'b00;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_plain_shapes();
      t_zero_src();
      t_reserved();
      t_start_state();
      t_segments();
      t_collision();
      t_marks_ignored();
      t_hold();
      t_random();
      t_reset_mid();
      summary();
   end
endmodule